// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block tells a memory controller when a periodic refresh is owed and keeps the command stream legal around it. A free-running interval timer adds one owed refresh to a backlog each time it expires. The refresh request stays raised while anything is owed, so the controller can defer refreshes behind normal traffic. The backlog is capped so that the gap between two refreshes stays under the device limit, and an urgent flag warns the arbiter when the cap is reached. Each accepted refresh blocks all commands for the refresh cycle time.

The block also handles the low-power retention state. On a request, and once all banks are idle, it drops the memory clock enable. While the memory sits in that state the interval timer holds its value and the backlog is cleared, because the memory refreshes itself. When the request is withdrawn, clock enable returns. Non-read commands are then held off for a short exit delay, and reads for a much longer one.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and after reset, `ref_req`, `ref_urgent`, `cmd_block` and `rd_block` are low and `cke` is high.
- R2: The interval timer advances on each clock outside self-refresh. Every `INTERVAL` cycles it adds one to the backlog. The first `ref_req` therefore appears exactly `INTERVAL` clock edges after reset is released, when no grant is given.
- R3: `ref_urgent` is high exactly when the backlog equals `MAX_PEND` outside self-refresh.
- R4: The backlog never exceeds `MAX_PEND`. Further interval expiries at the cap are dropped, so after `MAX_PEND` grants nothing is owed.
- R5: A grant is accepted on a clock edge where `ref_grant`, `ref_req` and `banks_idle` are all high. It removes one owed refresh. `cmd_block` is then high for exactly `RFC_CYC` cycles, and `ref_req` is low during that time.
- R6: A `ref_grant` that arrives while `banks_idle` is low, or while `ref_req` is low, has no effect on the backlog or on `cmd_block`.
- R7: Self-refresh is entered on the edge where `sr_req` and `banks_idle` are high, no command block is running and no refresh grant is accepted. `cke` goes low from that edge, and the backlog is cleared.
- R8: While in self-refresh, `ref_req` and `ref_urgent` are low, `cmd_block` and `rd_block` are high, and the interval timer keeps the value it had at entry.
- R9: On the first edge with `sr_req` low during self-refresh, `cke` returns high. `cmd_block` then stays high for exactly `XS_NRD` cycles.
- R10: After self-refresh exit, `rd_block` stays high for exactly `XS_RD` cycles, where `XS_RD` is at least `XS_NRD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | All banks are precharged |
| ref_grant | input | 1 | Controller issues the requested refresh this cycle |
| sr_req | input | 1 | Hold high to enter and stay in self-refresh |
| ref_req | output | 1 | At least one refresh is owed and may be issued |
| ref_urgent | output | 1 | Backlog has reached its cap |
| cmd_block | output | 1 | No command may be issued |
| rd_block | output | 1 | No read may be issued |
| cke | output | 1 | Clock enable to the memory |

## Verification
The assertions take two things for granted. The first is that `banks_idle` honestly reports precharged banks. The second is that the arbiter only counts a grant as a refresh when `ref_req` was high. The bench deliberately breaks the second with grants held through blocked periods, because the design must filter those itself. The stimulus changes inputs only just after a clock edge. Every check is placed at an edge count derived from `INTERVAL`, `RFC_CYC` and the exit delays, in a small configuration whose backlog can be filled and drained within a few interval periods.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INTERVAL = 1560,
  parameter int RFC_CYC  = 14,
  parameter int MAX_PEND = 8,
  parameter int XS_NRD   = 14,
  parameter int XS_RD    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic ref_grant,
  input  logic sr_req,
  output logic ref_req,
  output logic ref_urgent,
  output logic cmd_block,
  output logic rd_block,
  output logic cke
);
  localparam int IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam int RW = $clog2(RFC_CYC + 1);
  localparam int NW = $clog2(XS_NRD + 1);
  localparam int DW = $clog2(XS_RD + 1);

  logic [IW-1:0] ivl_q;
  logic [PW-1:0] pend_q;
  logic [RW-1:0] rfc_q;
  logic [NW-1:0] xn_q;
  logic [DW-1:0] xr_q;
  logic          sr_q;

  logic tick, take, sr_enter, sr_exit;

  assign tick     = !sr_q && (ivl_q == IW'(INTERVAL - 1));
  assign ref_req  = !sr_q && (pend_q != '0) && (rfc_q == '0) && (xn_q == '0);
  assign take     = ref_grant && ref_req && banks_idle;
  assign sr_enter = !sr_q && sr_req && banks_idle && (rfc_q == '0) && (xn_q == '0) && !take;
  assign sr_exit  = sr_q && !sr_req;

  assign ref_urgent = !sr_q && (pend_q == PW'(MAX_PEND));
  assign cmd_block  = sr_q || (rfc_q != '0) || (xn_q != '0);
  assign rd_block   = cmd_block || (xr_q != '0);
  assign cke        = !sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q <= '0;
      pend_q <= '0;
      rfc_q <= '0;
      xn_q <= '0;
      xr_q <= '0;
      sr_q <= 1'b0;
    end else begin
      if (!sr_q) ivl_q <= tick ? '0 : ivl_q + 1'b1;

      if (sr_enter || sr_q)
        pend_q <= '0;
      else if (tick && !take && (pend_q != PW'(MAX_PEND)))
        pend_q <= pend_q + 1'b1;
      else if (take && !tick)
        pend_q <= pend_q - 1'b1;

      if (take)              rfc_q <= RW'(RFC_CYC);
      else if (rfc_q != '0)  rfc_q <= rfc_q - 1'b1;

      if (sr_exit)           xn_q <= NW'(XS_NRD);
      else if (xn_q != '0)   xn_q <= xn_q - 1'b1;

      if (sr_exit)           xr_q <= DW'(XS_RD);
      else if (xr_q != '0)   xr_q <= xr_q - 1'b1;

      if (sr_enter)          sr_q <= 1'b1;
      else if (sr_exit)      sr_q <= 1'b0;
    end
  end

  a_r4_pend_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(MAX_PEND));

  a_r5_block_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant && ref_req && banks_idle) |=> (cmd_block && !ref_req));

  a_r6_grant_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_block) && cke) |-> $past(banks_idle));

  a_r7_entry_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(banks_idle) && $past(sr_req)));

  a_r8_quiet_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!ref_req && !ref_urgent && rd_block));

  a_r9_exit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd_block && rd_block));

  a_r3_urgent_stable_in_rfc: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent && !ref_grant && !sr_req) |=> ref_urgent);
endmodule

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
  localparam int IV = 20, RFC = 4, MP = 3, XN = 5, XR = 12;

  logic clk = 1'b0, rst_n = 1'b0, banks_idle = 1'b1, ref_grant = 1'b0, sr_req = 1'b0;
  logic ref_req, ref_urgent, cmd_block, rd_block, cke;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_refresh_sched #(.INTERVAL(IV), .RFC_CYC(RFC), .MAX_PEND(MP), .XS_NRD(XN), .XS_RD(XR)) u0 (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ref_grant(ref_grant), .sr_req(sr_req),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .cmd_block(cmd_block), .rd_block(rd_block), .cke(cke));

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; cyc++; end
  endtask

  task automatic to_edge(input int n);
    while (cyc < n) step(1);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int e_sr, frz;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "ref_req in reset", ref_req, 1'b0);
    chk("R1", "cke in reset", cke, 1'b1);
    rst_n = 1'b1;
    cyc = 0;
    chk("R1", "cmd_block", cmd_block, 1'b0);
    chk("R1", "rd_block", rd_block, 1'b0);
    chk("R1", "ref_urgent", ref_urgent, 1'b0);

    // R2: first request exactly IV edges after release
    to_edge(IV - 1);
    chk("R2", "ref_req before interval", ref_req, 1'b0);
    step(1);
    chk("R2", "ref_req at interval", ref_req, 1'b1);
    chk("R3", "urgent at backlog 1", ref_urgent, 1'b0);

    // R3: urgent when backlog reaches MP
    to_edge(MP * IV - 1);
    chk("R3", "urgent below cap", ref_urgent, 1'b0);
    step(1);
    chk("R3", "urgent at cap", ref_urgent, 1'b1);

    // R4/R5: backlog saturated; drain with a grant held high
    to_edge(5 * IV);
    chk("R4", "urgent still at cap", ref_urgent, 1'b1);
    ref_grant = 1'b1;
    for (int c = 1; c <= 16; c++) begin
      step(1);
      chk("R5", "cmd_block during drain", cmd_block, (c < 15) && (c % 5 != 0));
      chk("R5", "ref_req during drain", ref_req, (c < 15) && (c % 5 == 0));
      chk("R4", "urgent during drain", ref_urgent, 1'b0);
    end
    chk("R4", "nothing owed after cap grants", ref_req, 1'b0);
    chk("R6", "grant without request ignored", cmd_block, 1'b0);
    ref_grant = 1'b0;

    // R6: grant while banks busy is ignored
    to_edge(6 * IV);
    chk("R2", "backlog 1 at next interval", ref_req, 1'b1);
    banks_idle = 1'b0;
    ref_grant = 1'b1;
    for (int c = 1; c <= 3; c++) begin
      step(1);
      chk("R6", "request kept while busy", ref_req, 1'b1);
      chk("R6", "no block while busy", cmd_block, 1'b0);
    end
    banks_idle = 1'b1;
    step(1);
    chk("R5", "block after accepted grant", cmd_block, 1'b1);
    chk("R5", "request dropped after grant", ref_req, 1'b0);
    step(RFC);
    chk("R5", "block ends after RFC", cmd_block, 1'b0);
    chk("R5", "nothing owed", ref_req, 1'b0);
    ref_grant = 1'b0;

    // R7: entry waits for idle banks, clears backlog
    to_edge(7 * IV + 2);
    chk("R2", "owed before entry", ref_req, 1'b1);
    sr_req = 1'b1;
    banks_idle = 1'b0;
    step(2);
    chk("R7", "no entry while busy", cke, 1'b1);
    banks_idle = 1'b1;
    step(1);
    e_sr = cyc;
    frz = e_sr - 7 * IV;
    chk("R7", "cke low after entry", cke, 1'b0);
    chk("R8", "cmd_block in sr", cmd_block, 1'b1);
    chk("R8", "rd_block in sr", rd_block, 1'b1);
    for (int k = 1; k <= 100; k++) begin
      step(1);
      chk("R8", "no request in sr", ref_req, 1'b0);
      chk("R8", "no urgent in sr", ref_urgent, 1'b0);
      chk("R8", "cke stays low", cke, 1'b0);
    end

    // R9/R10: exit delays; timer resumes from frozen value, backlog empty
    sr_req = 1'b0;
    step(1);
    chk("R9", "cke high after exit", cke, 1'b1);
    chk("R9", "cmd_block at exit", cmd_block, 1'b1);
    chk("R10", "rd_block at exit", rd_block, 1'b1);
    for (int k = 1; k <= 20; k++) begin
      step(1);
      chk("R9", "cmd_block after exit", cmd_block, k < XN);
      chk("R10", "rd_block after exit", rd_block, k < XR);
      chk("R8", "timer resumes from frozen value", ref_req, k >= IV - frz);
    end
    finish_run();
  end
endmodule